// File: doc/BRIEF.md
# I/O Address Trap Monitor

This block watches processor I/O cycles and traps any access that lands in one of four programmable address windows. Each window is a 16-bit base address plus a 4-bit "don't care" mask over the low address nibble. Because each mask bit is independent, one window can cover a set of scattered addresses rather than a single contiguous range. On a trapped cycle the block sets a sticky per-window status bit. Software clears that bit by writing 1 to it. The SMI request output is the OR of the status bits whose windows have trapping enabled.

Trapping and forwarding are controlled separately. The cycle strobe carries a flag that tells whether the intended target sits downstream. When it does, a trapped cycle is passed downstream only if forwarding is enabled for every window that trapped it. Cycles meant for a local target always go to that target, whether they are trapped or not. A small register port gives software access to the bases, the packed mask register, the enable register and the status register.

Top module: `io_trap_monitor`

## Requirements
- R1: After reset every base, the mask register, all trap and forward enables and all status bits read 0, and smi_o is 0.
- R2: Register addresses 0 to 3 hold the 16-bit bases of monitors 0 to 3. A write takes effect at the clock edge, and reg_rdata_o returns the stored value combinationally.
- R3: Address 4 is the packed mask register. Bits 4k+3:4k are the mask of monitor k.
- R4: A monitor matches when every address bit whose mask bit is 0 equals the base, and all of bits 15:4 equal the base. With base 1230h and mask 0100b, 1230h and 1234h match and 1231h, 1238h and 1330h do not.
- R5: A match traps only when the monitor's trap enable is set. Address 5 bits 3:0 hold the trap enables, and trap_o shows a trapping cycle in the same clock.
- R6: Address 6 bits 3:0 are the status bits. A trapping cycle sets its bits at the next edge, and they stay set until a write of 1 clears them. When a set and a clear hit the same bit in the same cycle, the set wins.
- R7: smi_o is high exactly when some status bit is set and that monitor's trap enable is also set.
- R8: When several enabled monitors match one address, all of them set their status bits in the same clock.
- R9: For a downstream cycle (io_down_i=1), fwd_down_o is high unless a trapping monitor has its forward enable clear. The forward enables are address 5 bits 7:4.
- R10: For a local cycle (io_down_i=0), local_o is high and fwd_down_o is low, whether or not the cycle traps.
- R11: While io_valid_i is low, nothing traps, no status bit changes and both routing outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| io_valid_i | input | 1 | I/O cycle valid strobe |
| io_addr_i | input | 16 | I/O cycle address |
| io_down_i | input | 1 | Intended target is downstream |
| trap_o | output | 1 | Current cycle is trapped |
| local_o | output | 1 | Cycle is routed to the local target |
| fwd_down_o | output | 1 | Cycle is forwarded downstream |
| smi_o | output | 1 | SMI request |

## Verification
The bench probes the mask edges. It checks the two addresses the example mask admits and the neighbours that differ in an unmasked bit. A compare that inverts the mask sense, or that ignores the upper address bits, would trap 1231h or 1330h. It checks that a write-1 clear issued in the same cycle as a new trap leaves the bit set. A design that let the clear win would lose that event. It checks overlapping windows with mixed forward enables. A design that forwarded when any single trapping monitor allowed it would pass a cycle downstream that should have been blocked.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;
  localparam int unsigned IO_AW   = 16;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned N_MON   = 4;
  localparam int unsigned REG_DW  = 16;
  localparam int unsigned REG_AW  = 3;
endpackage

// File: rtl/io_trap_match.sv
module io_trap_match #(
  parameter int unsigned AW = io_trap_pkg::IO_AW,
  parameter int unsigned MW = io_trap_pkg::NIB_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [MW-1:0] mask_i,
  input  logic          en_i,
  output logic          hit_o
);
  logic [AW-1:0] care;
  logic          match;

  assign care  = ~{{(AW-MW){1'b0}}, mask_i};
  assign match = ((addr_i ^ base_i) & care) == '0;
  assign hit_o = match & en_i;

  // upper bits are never masked
  assert_upper_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (addr_i[AW-1:MW] == base_i[AW-1:MW]));
endmodule

// File: rtl/io_trap_regs.sv
module io_trap_regs #(
  parameter int unsigned N  = io_trap_pkg::N_MON,
  parameter int unsigned AW = io_trap_pkg::IO_AW,
  parameter int unsigned MW = io_trap_pkg::NIB_W,
  parameter int unsigned DW = io_trap_pkg::REG_DW,
  parameter int unsigned RA = io_trap_pkg::REG_AW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [RA-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [N-1:0]         set_i,
  output logic [DW-1:0]        rdata_o,
  output logic [N-1:0][AW-1:0] base_o,
  output logic [N*MW-1:0]      mask_o,
  output logic [N-1:0]         trap_en_o,
  output logic [N-1:0]         fwd_en_o,
  output logic [N-1:0]         status_o
);
  localparam logic [RA-1:0] A_MASK = RA'(N);
  localparam logic [RA-1:0] A_CTRL = RA'(N + 1);
  localparam logic [RA-1:0] A_STAT = RA'(N + 2);

  logic [N-1:0] clr;
  assign clr = (we_i && addr_i == A_STAT) ? wdata_i[N-1:0] : '0;

  for (genvar k = 0; k < N; k++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          base_o[k] <= '0;
      else if (we_i && addr_i == RA'(k))    base_o[k] <= wdata_i[AW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o    <= '0;
      trap_en_o <= '0;
      fwd_en_o  <= '0;
      status_o  <= '0;
    end else begin
      if (we_i && addr_i == A_MASK) mask_o <= wdata_i[N*MW-1:0];
      if (we_i && addr_i == A_CTRL) begin
        trap_en_o <= wdata_i[N-1:0];
        fwd_en_o  <= wdata_i[2*N-1:N];
      end
      status_o <= (status_o & ~clr) | set_i;  // set beats clear
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N; k++)
      if (addr_i == RA'(k)) rdata_o = DW'(base_o[k]);
    if (addr_i == A_MASK) rdata_o = DW'(mask_o);
    if (addr_i == A_CTRL) rdata_o = DW'({fwd_en_o, trap_en_o});
    if (addr_i == A_STAT) rdata_o = DW'(status_o);
  end

  assert_status_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~clr) != '0) |=>
      ((status_o & $past(status_o & ~clr)) == $past(status_o & ~clr)));
  assert_set_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/io_trap_monitor.sv
module io_trap_monitor
  import io_trap_pkg::*;
#(
  parameter int unsigned N  = N_MON,
  parameter int unsigned AW = IO_AW,
  parameter int unsigned MW = NIB_W,
  parameter int unsigned DW = REG_DW,
  parameter int unsigned RA = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [RA-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          io_valid_i,
  input  logic [AW-1:0] io_addr_i,
  input  logic          io_down_i,
  output logic          trap_o,
  output logic          local_o,
  output logic          fwd_down_o,
  output logic          smi_o
);
  logic [N-1:0][AW-1:0] base;
  logic [N*MW-1:0]      mask;
  logic [N-1:0]         trap_en, fwd_en, status, hit, trap_vec;
  logic                 blocked;

  io_trap_regs #(.N(N), .AW(AW), .MW(MW), .DW(DW), .RA(RA)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .set_i     (trap_vec),
    .rdata_o   (reg_rdata_o),
    .base_o    (base),
    .mask_o    (mask),
    .trap_en_o (trap_en),
    .fwd_en_o  (fwd_en),
    .status_o  (status)
  );

  for (genvar k = 0; k < N; k++) begin : g_mon
    io_trap_match #(.AW(AW), .MW(MW)) u_match (
      .clk_i, .rst_ni,
      .addr_i (io_addr_i),
      .base_i (base[k]),
      .mask_i (mask[k*MW +: MW]),
      .en_i   (trap_en[k]),
      .hit_o  (hit[k])
    );
  end

  assign trap_vec   = io_valid_i ? hit : '0;
  assign trap_o     = |trap_vec;
  assign blocked    = |(trap_vec & ~fwd_en);
  assign local_o    = io_valid_i & ~io_down_i;
  assign fwd_down_o = io_valid_i & io_down_i & ~blocked;
  assign smi_o      = |(status & trap_en);

  localparam logic [RA-1:0] A_STAT = RA'(N + 2);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_valid_i && !(reg_we_i && reg_addr_i == A_STAT)) |=> $stable(status));
  assert_local_route_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_valid_i && !io_down_i) |-> (local_o && !fwd_down_o));
  assert_fwd_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_down_o |-> ((trap_vec & ~fwd_en) == '0));
  assert_routing_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({local_o, fwd_down_o}));
endmodule

// File: tb/io_trap_monitor_test.sv
module io_trap_monitor_test;
  logic        clk_i = 0, rst_ni = 0;
  logic        reg_we_i = 0;
  logic [2:0]  reg_addr_i = 0;
  logic [15:0] reg_wdata_i = 0;
  logic [15:0] reg_rdata_o;
  logic        io_valid_i = 0, io_down_i = 0;
  logic [15:0] io_addr_i = 0;
  logic        trap_o, local_o, fwd_down_o, smi_o;
  int checks = 0, errors = 0;
  logic s_trap, s_local, s_fwd;

  always #10 clk_i = ~clk_i;

  io_trap_monitor uut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; #1 d = reg_rdata_o;
  endtask

  task automatic io(logic [15:0] a, logic down);
    @(negedge clk_i);
    io_valid_i = 1; io_addr_i = a; io_down_i = down;
    #2 s_trap = trap_o; s_local = local_o; s_fwd = fwd_down_o;
    @(negedge clk_i);
    io_valid_i = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int k = 0; k < 7; k++) begin
      rd(3'(k), d); check("R1 reg", d, 16'h0);
    end
    check("R1 smi", {15'b0, smi_o}, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    for (int k = 0; k < 4; k++) wr(3'(k), 16'hA000 + 16'(k * 16'h111));
    for (int k = 0; k < 4; k++) begin
      rd(3'(k), d); check("R2 base", d, 16'hA000 + 16'(k * 16'h111));
    end
    wr(4, 16'h3C5A); rd(4, d); check("R3 mask", d, 16'h3C5A);
  endtask

  task automatic t_match();
    logic [15:0] d;
    wr(0, 16'h1230); wr(1, 16'h4450); wr(2, 16'h0080); wr(3, 16'hFFFF);
    wr(4, 16'h00F4); wr(5, 16'h0003);
    wr(6, 16'h000F);
    io(16'h1230, 0); check("R4 1230", {15'b0, s_trap}, 1);
    io(16'h1234, 0); check("R4 1234", {15'b0, s_trap}, 1);
    io(16'h1231, 0); check("R4 1231", {15'b0, s_trap}, 0);
    io(16'h1238, 0); check("R4 1238", {15'b0, s_trap}, 0);
    io(16'h1330, 0); check("R4 1330", {15'b0, s_trap}, 0);
    io(16'h445F, 0); check("R3 nibble1", {15'b0, s_trap}, 1);
    io(16'h4460, 0); check("R3 nibble1 miss", {15'b0, s_trap}, 0);
    rd(6, d); check("R6 status", d, 16'h0003);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    wr(6, 16'h000F);
    io(16'h0080, 0); check("R5 disabled", {15'b0, s_trap}, 0);
    rd(6, d); check("R5 no status", d, 16'h0);
    check("R7 smi low", {15'b0, smi_o}, 0);
  endtask

  task automatic t_status();
    logic [15:0] d;
    io(16'h1230, 0);
    rd(6, d); check("R6 set", d, 16'h0001);
    check("R7 smi", {15'b0, smi_o}, 1);
    io(16'h1111, 0);
    rd(6, d); check("R6 sticky", d, 16'h0001);
    wr(5, 16'h0002); check("R7 masked by enable", {15'b0, smi_o}, 0);
    wr(5, 16'h0003); check("R7 reenabled", {15'b0, smi_o}, 1);
    // set and clear collide on monitor 0
    @(negedge clk_i);
    io_valid_i = 1; io_addr_i = 16'h1230; io_down_i = 0;
    reg_we_i = 1; reg_addr_i = 6; reg_wdata_i = 16'h0001;
    @(negedge clk_i);
    io_valid_i = 0; reg_we_i = 0;
    rd(6, d); check("R6 set wins", d, 16'h0001);
    wr(6, 16'h0001); rd(6, d); check("R6 w1c", d, 16'h0);
    check("R7 smi clear", {15'b0, smi_o}, 0);
  endtask

  task automatic t_multi();
    logic [15:0] d;
    wr(2, 16'h1234); wr(5, 16'h0005);
    io(16'h1234, 0);
    rd(6, d); check("R8 both", d, 16'h0005);
    wr(6, 16'h000F);
  endtask

  task automatic t_forward();
    io(16'h1230, 1);
    check("R9 blocked", {14'b0, s_trap, s_fwd}, 16'h2);
    wr(5, 16'h0015);
    io(16'h1230, 1); check("R9 allowed", {15'b0, s_fwd}, 1);
    io(16'h1234, 1); check("R9 mixed", {15'b0, s_fwd}, 0);
    wr(5, 16'h0055);
    io(16'h1234, 1); check("R9 all fwd", {15'b0, s_fwd}, 1);
    io(16'h7777, 1); check("R9 miss", {14'b0, s_local, s_fwd}, 16'h1);
    wr(6, 16'h000F);
  endtask

  task automatic t_local();
    wr(5, 16'h0005);
    io(16'h1230, 0);
    check("R10 local", {13'b0, s_trap, s_local, s_fwd}, 16'h6);
  endtask

  task automatic t_idle();
    logic [15:0] d;
    wr(6, 16'h000F);
    @(negedge clk_i);
    io_valid_i = 0; io_addr_i = 16'h1230; io_down_i = 1;
    #2 check("R11 outs", {13'b0, trap_o, local_o, fwd_down_o}, 16'h0);
    @(negedge clk_i);
    rd(6, d); check("R11 status", d, 16'h0);
  endtask

  initial begin
    #55 rst_ni = 1;
    t_reset(); t_regs(); t_match(); t_enable(); t_status();
    t_multi(); t_forward(); t_local(); t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule